// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for a single SDRAM burst. A column command (read or write) carries a 9-bit starting column. The mode settings select how many beats follow (1, 2, 4, 8, or a page-long run) and whether the beats step in linear order or in interleaved order. On every enabled clock the block presents one column address with a valid flag. It also raises a last flag on the final beat of a fixed-length burst.

A burst can be cut short by a stop command. It can also be replaced at once by a new column command on any cycle, since one column command may be issued every clock. A write-mode input can force write commands down to one beat, regardless of the programmed length. The clock-enable input freezes the whole block while it is low. Bank and row handling are not part of this block.

Top module: `sdr_burst_col_gen`

## Requirements
- R1: While reset is asserted and right after it, col_valid and col_last are 0 and col_addr is 0.
- R2: An enabled clock edge with cmd_start high and a legal configuration starts a burst. From the next cycle, col_valid is 1 and col_addr equals start_col. After that, the burst advances one beat per enabled clock.
- R3: bl_code 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. col_last is 1 exactly on the final beat, and col_valid is 0 on the cycle after it unless a new burst starts.
- R4: With ilv_mode=0 and a length of 2^k, beat i has the upper 9-k bits of start_col. Its low k bits equal (start_col + i) mod 2^k.
- R5: With ilv_mode=1 and a length of 2^k, beat i has the upper 9-k bits of start_col. Its low k bits equal the low k bits of start_col XOR i.
- R6: bl_code 111 with ilv_mode=0 is a page burst. Beat i is (start_col + i) mod 512, col_last never rises, and the burst continues until it is stopped or replaced.
- R7: A start carrying a reserved configuration is ignored. The reserved cases are bl_code 100, 101 and 110, and bl_code 111 with ilv_mode=1, without the single-write override. An idle block stays idle, and a running burst continues unchanged.
- R8: An enabled edge with cmd_stop high and no legal start ends a running burst, so col_valid is 0 from the next cycle.
- R9: A legal start during a running burst restarts at once: the next cycle shows the new start_col as beat 0. A legal start wins over cmd_stop on the same edge.
- R10: A start with cmd_write=1 and single_write=1 gives a one-beat burst (col_last=1) whatever bl_code and ilv_mode hold. Reads, and writes with single_write=0, use bl_code.
- R11: While clk_en is 0, no input has any effect and col_addr, col_valid and col_last hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes the block |
| cmd_start | input | 1 | Column command (read or write) this cycle |
| cmd_write | input | 1 | The column command is a write |
| cmd_stop | input | 1 | Burst stop command this cycle |
| start_col | input | 9 | Starting column address of the command |
| bl_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| single_write | input | 1 | Force writes to one beat |
| col_addr | output | 9 | Column address of the current beat |
| col_valid | output | 1 | col_addr carries a burst beat |
| col_last | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Each result is due one enabled clock after its cause. A start edge shows beat 0 on the following cycle, and every later enabled edge moves to the next beat. A stop or the final beat clears col_valid on the next cycle. A disabled cycle leaves every output unchanged. The bench drives inputs on the falling edge and samples on the next falling edge, so every sample falls exactly one rising edge after the stimulus it checks. Expected addresses come from block arithmetic in the bench, over every start column, every fixed length and both orders.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;
  localparam int COL_W = 9;

  typedef logic [COL_W-1:0] col_t;

  typedef struct packed {
    logic legal;
    logic full;
    logic ilv;
    col_t mask;
  } burst_cfg_t;

  // Map the length code, order and single-beat override to a beat mask.
  function automatic burst_cfg_t decode_cfg(logic [2:0] code, logic ilv, logic one_beat);
    burst_cfg_t c;
    c = '0;
    if (one_beat) begin
      c.legal = 1'b1;
    end else if (code[2] == 1'b0) begin
      c.legal = 1'b1;
      c.ilv   = ilv;
      c.mask  = ~(col_t'('1) << code);
    end else if (code == 3'b111 && !ilv) begin
      c.legal = 1'b1;
      c.full  = 1'b1;
      c.mask  = '1;
    end
    return c;
  endfunction

  // Address of a beat: bits above the mask come from the base, bits inside step.
  function automatic col_t beat_addr(col_t base, col_t beat, col_t mask, logic ilv);
    col_t low;
    if (ilv) low = base ^ beat;
    else     low = base + beat;
    return (base & ~mask) | (low & mask);
  endfunction
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import sdr_col_pkg::*;
(
  input  logic [2:0]  bl_code,
  input  logic        ilv_mode,
  input  logic        cmd_write,
  input  logic        single_write,
  output burst_cfg_t  cfg
);
  logic one_beat;
  assign one_beat = cmd_write && single_write;
  assign cfg      = decode_cfg(bl_code, ilv_mode, one_beat);
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import sdr_col_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic        cmd_start,
  input  logic        cmd_stop,
  input  col_t        start_col,
  input  burst_cfg_t  cfg,
  output logic        active,
  output col_t        beat,
  output col_t        base,
  output col_t        mask,
  output logic        ilv,
  output logic        is_last,
  output logic        load_evt,
  output logic        stop_evt,
  output logic        done_evt
);
  logic active_q, full_q, ilv_q;
  col_t beat_q, base_q, mask_q;

  assign load_evt = clk_en && cmd_start && cfg.legal;
  assign stop_evt = clk_en && cmd_stop && !load_evt && active_q;
  assign is_last  = active_q && !full_q && (beat_q == mask_q);
  assign done_evt = clk_en && is_last && !load_evt && !stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
    end else if (load_evt) begin
      active_q <= 1'b1;
      full_q   <= cfg.full;
      ilv_q    <= cfg.ilv;
      beat_q   <= '0;
      base_q   <= start_col;
      mask_q   <= cfg.mask;
    end else if (stop_evt || done_evt) begin
      active_q <= 1'b0;
    end else if (clk_en && active_q) begin
      beat_q <= beat_q + col_t'(1);
    end
  end

  assign active = active_q;
  assign beat   = beat_q;
  assign base   = base_q;
  assign mask   = mask_q;
  assign ilv    = ilv_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sdr_col_pkg::*;
(
  input  col_t  base,
  input  col_t  beat,
  input  col_t  mask,
  input  logic  ilv,
  output col_t  addr
);
  assign addr = beat_addr(base, beat, mask, ilv);
endmodule

// File: rtl/sdr_burst_col_gen.sv
module sdr_burst_col_gen
  import sdr_col_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             cmd_start,
  input  logic             cmd_write,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             ilv_mode,
  input  logic             single_write,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last
);
  burst_cfg_t cfg;
  logic       active, ilv, is_last, load_evt, stop_evt, done_evt;
  col_t       beat, base, beat_mask;
  logic       cfg_legal;

  burst_cfg_decode u_dec (
    .bl_code      (bl_code),
    .ilv_mode     (ilv_mode),
    .cmd_write    (cmd_write),
    .single_write (single_write),
    .cfg          (cfg)
  );

  burst_beat_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .start_col (start_col),
    .cfg       (cfg),
    .active    (active),
    .beat      (beat),
    .base      (base),
    .mask      (beat_mask),
    .ilv       (ilv),
    .is_last   (is_last),
    .load_evt  (load_evt),
    .stop_evt  (stop_evt),
    .done_evt  (done_evt)
  );

  burst_addr_gen u_addr (
    .base (base),
    .beat (beat),
    .mask (beat_mask),
    .ilv  (ilv),
    .addr (col_addr)
  );

  assign cfg_legal = cfg.legal;
  assign col_valid = active;
  assign col_last  = is_last;
endmodule

// File: rtl/sdr_burst_col_chk.sv
module sdr_burst_col_chk
  import sdr_col_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last,
  input logic             load_evt,
  input logic             stop_evt,
  input logic             done_evt,
  input logic             cfg_legal,
  input logic [COL_W-1:0] beat_mask
);
  // R2: a legal start shows its column as beat 0 on the next cycle
  a_r2_load_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> col_valid && (col_addr == $past(start_col)));

  // R3: the last flag only marks a valid beat
  a_r3_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  // R3: an enabled final beat without a new start ends the burst
  a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && col_last && !load_evt |=> !col_valid);

  // R8: stop without a legal start clears valid next cycle
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && cmd_stop && !load_evt |=> !col_valid);

  // R9: start wins over stop on the same edge
  a_r9_start_over_stop: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && cmd_stop |=> col_valid);

  // R4: bits above the beat mask stay fixed across a continuing burst
  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && col_valid && !load_evt && !stop_evt && !done_evt |=>
      col_valid && ((col_addr & ~beat_mask) == ($past(col_addr) & ~$past(beat_mask))));

  // R7: a reserved start on an idle block leaves it idle
  a_r7_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && cmd_start && !cfg_legal && !col_valid |=> !col_valid);

  // R11: a disabled clock holds every output
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(col_addr) && $stable(col_valid) && $stable(col_last));
endmodule

bind sdr_burst_col_gen sdr_burst_col_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .cmd_start (cmd_start),
  .cmd_stop  (cmd_stop),
  .start_col (start_col),
  .col_addr  (col_addr),
  .col_valid (col_valid),
  .col_last  (col_last),
  .load_evt  (load_evt),
  .stop_evt  (stop_evt),
  .done_evt  (done_evt),
  .cfg_legal (cfg_legal),
  .beat_mask (beat_mask)
);

// File: tb/sdr_burst_col_gen_tb.sv
module sdr_burst_col_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n, clk_en, cmd_start, cmd_write, cmd_stop, ilv_mode, single_write;
  logic [8:0] start_col;
  logic [2:0] bl_code;
  logic [8:0] col_addr;
  logic       col_valid, col_last;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_burst_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_start(cmd_start),
    .cmd_write(cmd_write), .cmd_stop(cmd_stop), .start_col(start_col),
    .bl_code(bl_code), .ilv_mode(ilv_mode), .single_write(single_write),
    .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got cycles=%0d expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Beat i of a burst of length bl from column s, computed by block arithmetic.
  function automatic int exp_addr(int s, int bl, bit ilv, bit full, int i);
    int blk, off;
    if (full) return (s + i) % 512;
    blk = s - (s % bl);
    off = s % bl;
    if (ilv) return blk + (off ^ i);
    return blk + ((off + i) % bl);
  endfunction

  task automatic chk(string tag, logic ev, int ea, logic el, bit use_addr);
    n_tests++;
    if (col_valid !== ev || col_last !== el ||
        (use_addr && col_addr !== 9'(ea))) begin
      n_fail++;
      $display("FAIL %s: got v=%0b a=%0d l=%0b expected v=%0b a=%0d l=%0b",
               tag, col_valid, col_addr, col_last, ev, ea, el);
    end
  endtask

  task automatic issue(int s, int code, bit ilv, bit wr, bit sw);
    start_col    = 9'(s);
    bl_code      = 3'(code);
    ilv_mode     = ilv;
    cmd_write    = wr;
    single_write = sw;
    cmd_start    = 1'b1;
  endtask

  task automatic run_burst(string tag, int s, int code, bit ilv, bit wr, bit sw, int ebl);
    issue(s, code, ilv, wr, sw);
    for (int i = 0; i < ebl; i++) begin
      @(negedge clk);
      chk(tag, 1'b1, exp_addr(s, ebl, ilv, 1'b0, i), (i == ebl - 1), 1'b1);
      cmd_start = 1'b0;
    end
    @(negedge clk);
    chk(tag, 1'b0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; cmd_start = 1'b0; cmd_write = 1'b0;
    cmd_stop = 1'b0; ilv_mode = 1'b0; single_write = 1'b0;
    start_col = '0; bl_code = '0;
    @(negedge clk);
    chk("R1 in reset", 1'b0, 0, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 0, 1'b0, 1'b1);

    // R2 R3 R4 R5: every start column, every fixed length, both orders
    for (int s = 0; s < 512; s++)
      for (int code = 0; code < 4; code++)
        for (int ilv = 0; ilv < 2; ilv++)
          run_burst(ilv ? "R2 R3 R5 interleave" : "R2 R3 R4 linear",
                    s, code, ilv[0], 1'b0, 1'b0, 1 << code);

    // R6: page burst wraps past 511, never flags last; R8 stop ends it
    issue(505, 7, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 520; i++) begin
      @(negedge clk);
      chk("R6 page burst", 1'b1, exp_addr(505, 512, 1'b0, 1'b1, i), 1'b0, 1'b1);
      cmd_start = 1'b0;
    end
    cmd_stop = 1'b1;
    @(negedge clk);
    chk("R8 stop page burst", 1'b0, 0, 1'b0, 1'b0);
    cmd_stop = 1'b0;

    // R8: stop mid fixed burst
    issue(64, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 beat0", 1'b1, 64, 1'b0, 1'b1);
    cmd_start = 1'b0;
    @(negedge clk);
    chk("R8 beat1", 1'b1, 65, 1'b0, 1'b1);
    cmd_stop = 1'b1;
    @(negedge clk);
    chk("R8 stop mid burst", 1'b0, 0, 1'b0, 1'b0);
    cmd_stop = 1'b0;

    // R7: reserved codes on an idle block
    for (int k = 0; k < 4; k++) begin
      if (k < 3) issue(10, 4 + k, 1'b0, 1'b0, 1'b0);
      else       issue(10, 7, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk("R7 reserved idle", 1'b0, 0, 1'b0, 1'b0);
      cmd_start = 1'b0;
    end

    // R7: reserved start during a running burst does not disturb it
    issue(16, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 beat0", 1'b1, 16, 1'b0, 1'b1);
    issue(100, 5, 1'b0, 1'b0, 1'b0);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      chk("R7 burst continues", 1'b1, 16 + i, (i == 7), 1'b1);
      cmd_start = 1'b0;
    end
    @(negedge clk);
    chk("R7 burst end", 1'b0, 0, 1'b0, 1'b0);

    // R9: interrupt by a new legal start
    issue(40, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 beat0", 1'b1, 40, 1'b0, 1'b1);
    cmd_start = 1'b0;
    @(negedge clk);
    chk("R9 beat1", 1'b1, 41, 1'b0, 1'b1);
    issue(202, 2, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 restarted burst", 1'b1, 200 + (2 ^ i), (i == 3), 1'b1);
      cmd_start = 1'b0;
    end
    @(negedge clk);
    chk("R9 end", 1'b0, 0, 1'b0, 1'b0);

    // R9: start and stop on the same edge, start wins
    issue(120, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmd_start = 1'b0;
    issue(300, 1, 1'b0, 1'b0, 1'b0);
    cmd_stop = 1'b1;
    @(negedge clk);
    chk("R9 start beats stop", 1'b1, 300, 1'b0, 1'b1);
    cmd_start = 1'b0;
    cmd_stop  = 1'b0;
    @(negedge clk);
    chk("R9 second beat", 1'b1, 301, 1'b1, 1'b1);
    @(negedge clk);
    chk("R9 done", 1'b0, 0, 1'b0, 1'b0);

    // R10: single write override
    run_burst("R10 single write", 77, 3, 1'b0, 1'b1, 1'b1, 1);
    run_burst("R10 single write reserved code", 78, 5, 1'b1, 1'b1, 1'b1, 1);
    run_burst("R10 burst write", 77, 3, 1'b0, 1'b1, 1'b0, 8);
    run_burst("R10 read ignores override", 77, 3, 1'b1, 1'b0, 1'b1, 8);

    // R11: disabled clock freezes state and ignores inputs
    issue(8, 2, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R11 beat0", 1'b1, 8, 1'b0, 1'b1);
    clk_en = 1'b0;
    issue(400, 0, 1'b0, 1'b0, 1'b0);
    cmd_stop = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 frozen", 1'b1, 8, 1'b0, 1'b1);
    end
    clk_en = 1'b1; cmd_start = 1'b0; cmd_stop = 1'b0;
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk("R11 resumed", 1'b1, 8 + i, (i == 3), 1'b1);
    end
    @(negedge clk);
    chk("R11 end", 1'b0, 0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule